// File: doc/BRIEF.md
# Strobed Parallel Bus Master

This block sits between a simple CPU-side request port and a parallel bus whose control lines are active low. The CPU marks an instruction by holding `busy` high. Inside it, the CPU issues a one-cycle read or write request pulse, and presents the target address in the same cycle. For a write it also presents the data word. The block stores the address and the write data in its own registers. It then runs one bus cycle that ends when the slave acknowledges, and it signals the end with a one-cycle `done` pulse.

On the bus side the address strobe is held low for the whole bus cycle, and the write strobe is also low when the cycle is a write. The block waits for the slave to pull the acknowledge line low. Read data coming back from the slave is captured into a data-in register, which the CPU reads after `done`. Outgoing and incoming data use separate ports, so the block contains no tri-state logic. Every register runs on the one clock and uses its own enable.

Top module: `pbus_master`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) returns the block to idle. Afterwards `as_n`=1, `wr_n`=1, `done`=0, and `bus_addr`, `bus_wdata` and `rdata` are all zero.
- R2: A `rd_req` pulse seen at a rising edge while idle and `busy`=1 latches `addr_in`. From the next cycle, `as_n`=0, `wr_n`=1 and `bus_addr` shows the latched address.
- R3: A `wr_req` pulse seen while idle and `busy`=1 latches `addr_in` and `wdata_in`. From the next cycle, `as_n`=0 and `wr_n`=0, with `bus_addr` and `bus_wdata` showing the latched values.
- R4: `as_n` stays low until `ack_n` is sampled low at a rising edge. It goes high in the cycle after that edge.
- R5: On a read, `bus_rdata` is captured into `rdata` at the edge where `ack_n` is sampled low. `rdata` keeps its value until the next read is acknowledged, and a write leaves it unchanged.
- R6: `done` is high for exactly one cycle, in the cycle right after `ack_n` is sampled low. That same cycle, `as_n` and `wr_n` are both high.
- R7: During a bus cycle and during the `done` cycle, the block ignores request pulses and any change on `addr_in` or `wdata_in`. The bus outputs keep the latched values.
- R8: A request pulse seen while `busy`=0 is ignored, and `as_n` stays high.
- R9: If `rd_req` and `wr_req` arrive in the same cycle, the block runs a write.
- R10: A reset during a bus cycle aborts it. `as_n` and `wr_n` go high, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | CPU instruction in progress |
| rd_req | input | 1 | One-cycle read request |
| wr_req | input | 1 | One-cycle write request |
| addr_in | input | AW | Request address |
| wdata_in | input | DW | Request write data |
| ack_n | input | 1 | Slave acknowledge, active low |
| bus_rdata | input | DW | Data returned by the slave |
| bus_addr | output | AW | Latched address on the bus |
| bus_wdata | output | DW | Latched write data on the bus |
| as_n | output | 1 | Address strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | DW | Data-in register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The state machine has only three states, so a wrong state shows at the ports within one cycle. A stuck state leaves `as_n` low after an acknowledge, or gives a `done` pulse that is too long or missing. A wrongly accepted request shows on `bus_addr` or `as_n` at the next sample. A bad enable on the address, write-data or data-in register shows either while the strobe is low or during the `done` cycle. The bench checks every cycle of each transaction, using random acknowledge delays and request pulses injected in the middle of a bus cycle.

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          ack_n,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          as_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          done
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_DONE} st_t;

  st_t           st;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;

  wire take   = (st == ST_IDLE) && busy && (rd_req || wr_req);
  wire finish = (st == ST_BUS) && !ack_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take) st <= ST_BUS;
        ST_BUS:  if (finish) st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
      if (take) begin
        wr_q   <= wr_req;
        addr_q <= addr_in;
        if (wr_req) wdat_q <= wdata_in;
      end
      if (finish && !wr_q) rdat_q <= bus_rdata;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;
  assign rdata     = rdat_q;
  assign as_n      = (st != ST_BUS);
  assign wr_n      = !((st == ST_BUS) && wr_q);
  assign done      = (st == ST_DONE);
endmodule

module pbus_master_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req,
  input logic          wr_req,
  input logic          ack_n,
  input logic [AW-1:0] bus_addr,
  input logic          as_n,
  input logic          wr_n,
  input logic          done
);
  // R3
  wr_strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !as_n);
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !ack_n) |=> as_n);
  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !ack_n) |=> done);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_strobes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (as_n && wr_n));
  // R2
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> $past(rd_req || wr_req));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!as_n && $past(!as_n)) |-> $stable(bus_addr));
endmodule

bind pbus_master pbus_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .ack_n(ack_n),
  .bus_addr(bus_addr), .as_n(as_n), .wr_n(wr_n), .done(done)
);

// File: tb/tb_pbus_master.sv
module tb_pbus_master;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 0, rst = 1, busy = 0, rd_req = 0, wr_req = 0, ack_n = 1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wdata_in = '0, bus_rdata = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rdata;
  logic as_n, wr_n, done;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_rd = '0;
  logic [DW-1:0] exp_wd = '0;

  pbus_master #(.AW(AW), .DW(DW)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rdata(input logic is_w, input logic [DW-1:0] old,
                                               input logic [DW-1:0] rd);
    return is_w ? old : rd;
  endfunction

  task automatic txn(input logic is_w, input logic both, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input int lat, input logic [DW-1:0] rd,
                     input logic stray);
    @(negedge clk);
    busy = 1; addr_in = a; wdata_in = d;
    rd_req = !is_w || both; wr_req = is_w;
    @(negedge clk);
    rd_req = 0; wr_req = 0; addr_in = $urandom; wdata_in = $urandom;
    if (is_w) exp_wd = d;
    chk(is_w ? "R3 as_n" : "R2 as_n", as_n, 0);
    chk(both ? "R9 wr_n" : (is_w ? "R3 wr_n" : "R2 wr_n"), wr_n, !is_w);
    chk("R2 bus_addr", bus_addr, a);
    chk("R3 bus_wdata", bus_wdata, exp_wd);
    for (int i = 0; i < lat; i++) begin
      if (stray) begin
        rd_req = $urandom % 2; wr_req = !rd_req; addr_in = $urandom; wdata_in = $urandom;
      end
      @(negedge clk);
      rd_req = 0; wr_req = 0;
      chk("R4 as_n held", as_n, 0);
      chk("R7 addr held", bus_addr, a);
      chk("R7 wdata held", bus_wdata, exp_wd);
      chk("R6 no early done", done, 0);
    end
    ack_n = 0; bus_rdata = rd;
    @(negedge clk);
    ack_n = 1; bus_rdata = $urandom;
    exp_rd = exp_rdata(is_w, exp_rd, rd);
    if (stray) begin rd_req = 1; addr_in = $urandom; end
    chk("R6 done", done, 1);
    chk("R4 as_n released", as_n, 1);
    chk("R6 wr_n high", wr_n, 1);
    chk("R5 rdata", rdata, exp_rd);
    @(negedge clk);
    rd_req = 0;
    chk("R6 done one cycle", done, 0);
    chk("R7 no restart", as_n, 1);
    chk("R5 rdata held", rdata, exp_rd);
    busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 as_n", as_n, 1);
    chk("R1 wr_n", wr_n, 1);
    chk("R1 done", done, 0);
    chk("R1 bus_addr", bus_addr, 0);
    chk("R1 bus_wdata", bus_wdata, 0);
    chk("R1 rdata", rdata, 0);

    // R8: busy low, request ignored
    @(negedge clk);
    rd_req = 1; addr_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_req = 0;
    chk("R8 as_n", as_n, 1);
    chk("R8 bus_addr", bus_addr, 0);

    // directed
    txn(0, 0, 32'h0000_0010, 32'h0, 0, 32'hA5A5_0001, 0);
    txn(1, 0, 32'h8000_0004, 32'h1234_5678, 3, 32'hFFFF_FFFF, 1);
    txn(1, 1, 32'h0000_0020, 32'hCAFE_F00D, 1, 32'h0, 0);
    txn(0, 0, 32'hFFFF_FFFC, 32'h0, 5, 32'h0BAD_0BAD, 1);

    // R10: reset mid-cycle
    @(negedge clk);
    busy = 1; wr_req = 1; addr_in = 32'h55; wdata_in = 32'h66;
    @(negedge clk);
    wr_req = 0;
    chk("R10 started", as_n, 0);
    rst = 1;
    @(negedge clk);
    rst = 0; busy = 0;
    exp_rd = '0; exp_wd = '0;
    chk("R10 as_n", as_n, 1);
    chk("R10 wr_n", wr_n, 1);
    chk("R10 bus_addr", bus_addr, 0);
    @(negedge clk);
    chk("R10 no done", done, 0);

    for (int n = 0; n < 60; n++) begin
      logic w;
      w = $urandom % 2;
      txn(w, w && ($urandom % 4 == 0), $urandom, $urandom, $urandom % 6, $urandom,
          $urandom % 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule